// File: doc/BRIEF.md
# PWM phase doubler sequencer

This block takes a single pulse-width-modulated stream from a multiphase controller and spreads it over two power-stage channels. Each line carries one of three levels, encoded as a 2-bit code: LOW, HIGH or TRI, where TRI is the high-impedance level. In the two interleaving modes, successive input pulses go to the two channels in turn, so the channels run half a period apart at half the input rate. In synchronous mode, every input pulse drives both channels at once.

Each channel's falling edge can be stretched. The stretch has two parts: a fixed mode offset, and a variable amount given on the channel whose sensed current is lower. This evens out the load between the two phases. The block also handles:
- a hold-off filter on TRI input;
- the enable input;
- arming on the first rising edge after enable;
- a fault override that pulls both outputs LOW while the block waits to arm.

All timing is counted in system clock cycles. The input is sampled on each rising clock edge, and the outputs follow from registered state one cycle later. The enable and fault inputs act on the outputs combinationally.

Top module: `phase_doubler`

## Requirements
- R1: Level codes are 2'b00 LOW, 2'b01 HIGH and 2'b10 TRI; an input code of 2'b11 is treated as TRI. After reset, both outputs read TRI and the steering points at channel A.
- R2: With `mode` set to 2'b00 or 2'b01 (interleaving), each input rising edge starts a pulse on the channel the steering points at and then flips the steering. The first pulse after reset or re-enable goes to A, and successive pulses alternate A, B, A, and so on.
- R3: With `mode[1]` set to 1 (synchronous), each input rising edge drives both outputs HIGH on the same cycle, and both return LOW together when no stretch applies.
- R4: A channel output is HIGH from the cycle after the input is sampled HIGH until the cycle after the input is sampled LOW, plus its stretch in extra cycles.
- R5: A run of TRI input samples shorter than HOLD_CYC (13) leaves both outputs unchanged. The 13th consecutive TRI sample drives both outputs to TRI and clears any pulse in progress.
- R6: While `en` is low, both outputs are TRI and the steering returns to A. After `en` rises, both outputs stay TRI until the first input rising edge, and that edge starts steering.
- R7: While the block waits for its first rising edge with `en` high, a high `ov_fault` drives both outputs LOW instead of TRI.
- R8: In mode 2'b00, the stretch is min(`imb_mag`, 14) cycles on the channel with lower current (A when `a_low` is 1, B when it is 0), and 0 on the other channel.
- R9: In mode 2'b01, every stretch gets an extra fixed 24 cycles on top of the variable part from R8.
- R10: In synchronous mode, only the variable part from R8 applies.
- R11: A new input rising edge ends any stretch still running, on either channel, in the same cycle that the next pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low disables the block and forces re-arming |
| mode | input | 2 | 00 interleave, 01 interleave with fixed offset, 1x synchronous |
| pwm_in | input | 2 | Three-level input code |
| imb_mag | input | 4 | Magnitude of the current imbalance, in stretch cycles |
| a_low | input | 1 | 1 when channel A carries the lower current |
| ov_fault | input | 1 | Overvoltage fault flag |
| pwm_a | output | 2 | Channel A three-level output code |
| pwm_b | output | 2 | Channel B three-level output code |

## Verification
The steering is first checked with a fixed stream of short LOW/HIGH pulses in interleaving mode. This stream separates correct alternation from a stuck or double-toggling steering bit, and it also covers the unarmed TRI phase ahead of the first edge.

The same kind of pulse is then repeated under several conditions:
- synchronous mode, where both channels must follow every pulse;
- each stretch setting, where the exact cycle the output drops shows whether the fixed offset is added, whether the magnitude saturates and whether the right channel is stretched;
- a rising edge that lands in the middle of a stretch.

TRI runs of 12 and 13 samples pin the hold-off boundary. Enable and fault sequences confirm re-arming and the LOW override.

// File: rtl/phase_doubler.sv
module phase_doubler #(
  parameter int HOLD_CYC = 13,
  parameter int VAR_MAX  = 14,
  parameter int FIX_EXT  = 24,
  parameter int MW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [1:0]    pwm_in,
  input  logic [MW-1:0] imb_mag,
  input  logic          a_low,
  input  logic          ov_fault,
  output logic [1:0]    pwm_a,
  output logic [1:0]    pwm_b
);
  localparam logic [1:0] LV_LO = 2'b00;
  localparam logic [1:0] LV_HI = 2'b01;
  localparam logic [1:0] LV_TR = 2'b10;
  localparam int CW = $clog2(FIX_EXT + VAR_MAX + 1);
  localparam int TW = $clog2(HOLD_CYC + 1);

  logic          armed, sel, last_hi, hi_a, hi_b;
  logic [TW-1:0] tri_cnt;
  logic [CW-1:0] ext_a, ext_b, var_amt, fix_amt, len_a, len_b;

  wire in_tri   = pwm_in[1];
  wire in_hi    = (pwm_in == LV_HI);
  wire rise     = in_hi && !last_hi;
  wire is_sync  = mode[1];
  wire tri_out  = (tri_cnt == TW'(HOLD_CYC));
  wire hold_hit = in_tri && (tri_cnt == TW'(HOLD_CYC - 1));
  wire on_a     = hi_a || (ext_a != '0);
  wire on_b     = hi_b || (ext_b != '0);

  assign var_amt = (CW'(imb_mag) > CW'(VAR_MAX)) ? CW'(VAR_MAX) : CW'(imb_mag);
  assign fix_amt = (mode == 2'b01) ? CW'(FIX_EXT) : '0;
  assign len_a   = fix_amt + (a_low ? var_amt : '0);
  assign len_b   = fix_amt + (a_low ? '0 : var_amt);

  assign pwm_a = !en ? LV_TR : !armed ? (ov_fault ? LV_LO : LV_TR) :
                 tri_out ? LV_TR : (on_a ? LV_HI : LV_LO);
  assign pwm_b = !en ? LV_TR : !armed ? (ov_fault ? LV_LO : LV_TR) :
                 tri_out ? LV_TR : (on_b ? LV_HI : LV_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      armed <= 1'b0; sel <= 1'b0; last_hi <= 1'b0;
      hi_a <= 1'b0; hi_b <= 1'b0; ext_a <= '0; ext_b <= '0; tri_cnt <= '0;
    end else if (in_tri) begin
      if (!tri_out) tri_cnt <= tri_cnt + 1'b1;
      if (hold_hit) begin
        hi_a <= 1'b0; hi_b <= 1'b0; ext_a <= '0; ext_b <= '0; last_hi <= 1'b0;
      end
    end else begin
      tri_cnt <= '0;
      last_hi <= in_hi;
      if (rise) begin
        armed <= 1'b1;
        ext_a <= '0; ext_b <= '0;
        if (is_sync) begin
          hi_a <= 1'b1; hi_b <= 1'b1;
        end else begin
          hi_a <= !sel; hi_b <= sel; sel <= !sel;
        end
      end else if (!in_hi) begin
        if (hi_a) begin hi_a <= 1'b0; ext_a <= len_a; end
        else if (ext_a != '0) ext_a <= ext_a - 1'b1;
        if (hi_b) begin hi_b <= 1'b0; ext_b <= len_b; end
        else if (ext_b != '0) ext_b <= ext_b - 1'b1;
      end
    end
  end

  // R2
  alt_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise && !in_tri && !is_sync) |=> (!en || ((pwm_a == LV_HI) != (pwm_b == LV_HI))));
  // R2
  steer_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise && !is_sync) |=> (!en || sel != $past(sel)));
  // R3
  sync_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise && is_sync) |=> (!en || (pwm_a == LV_HI && pwm_b == LV_HI)));
  // R5
  short_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && armed && in_tri && (tri_cnt < TW'(HOLD_CYC - 1)))
      |=> (!en || ($stable(pwm_a) && $stable(pwm_b))));
  // R6
  rearm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en ##1 (en && !ov_fault)) |-> (pwm_a == LV_TR && pwm_b == LV_TR));
  // R9
  ext_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_a <= CW'(FIX_EXT + VAR_MAX)) && (ext_b <= CW'(FIX_EXT + VAR_MAX)));
  // R8
  var_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00 && hi_a && pwm_in == LV_LO) |=> (!en || ext_a <= CW'(VAR_MAX)));
endmodule

// File: tb/test_phase_doubler.sv
`timescale 1ns/1ps
module test_phase_doubler;
  localparam logic [1:0] L = 2'b00, H = 2'b01, T = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, a_low = 1'b0, ov_fault = 1'b0;
  logic [1:0] mode = 2'b00, pin = 2'b00;
  logic [3:0] imb_mag = 4'd0;
  logic [1:0] pwm_a, pwm_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_doubler i_phase_doubler (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pwm_in(pin),
    .imb_mag(imb_mag), .a_low(a_low), .ov_fault(ov_fault),
    .pwm_a(pwm_a), .pwm_b(pwm_b));

  // {input, expected A, expected B}, interleaving, no stretch, fresh reset
  localparam logic [5:0] VEC [0:8] = '{
    {L, T, T}, {L, T, T}, {H, H, L}, {H, H, L}, {L, L, L},
    {H, L, H}, {L, L, L}, {H, H, L}, {L, L, L}};

  task automatic step(input logic [1:0] v);
    @(negedge clk); pin = v; @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [1:0] ea, input logic [1:0] eb);
    checks++;
    if (pwm_a !== ea || pwm_b !== eb) begin
      fails++;
      $display("FAIL %s: a=%b b=%b expected a=%b b=%b at %0t", tag, pwm_a, pwm_b, ea, eb, $time);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; ov_fault = 1'b0; mode = 2'b00; imb_mag = 4'd0; a_low = 1'b0; pin = L;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // runs a pulse then counts LOW samples until the stretched channel drops
  task automatic stretch(input string tag, input bit on_a, input int n);
    step(H); step(H);
    for (int k = 1; k <= n + 1; k++) begin
      step(L);
      if (on_a) chk(tag, (k <= n) ? H : L, L);
      else      chk(tag, L, (k <= n) ? H : L);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1 chk("R1", T, T);
    for (int i = 0; i < 9; i++) begin
      step(VEC[i][5:4]);
      chk("R2", VEC[i][3:2], VEC[i][1:0]);
    end

    // fault override while unarmed
    do_reset();
    ov_fault = 1'b1;
    step(L); chk("R7", L, L);
    ov_fault = 1'b0;
    step(L); chk("R7", T, T);
    step(H); chk("R2", H, L);

    // synchronous, then variable stretch on B only
    do_reset();
    mode = 2'b10;
    step(H); chk("R3", H, H);
    step(H); step(L); chk("R3", L, L);
    imb_mag = 4'd4; a_low = 1'b0;
    stretch("R10", 1'b0, 4);

    // mode 00: stretch on lower channel only
    do_reset();
    imb_mag = 4'd5; a_low = 1'b1;
    stretch("R8", 1'b1, 5);
    step(H); chk("R8", L, H);
    step(L); chk("R8", L, L);

    // saturation of the variable part
    do_reset();
    imb_mag = 4'd15; a_low = 1'b1;
    stretch("R8", 1'b1, 14);

    // mode 01: fixed offset, then fixed plus variable on B
    do_reset();
    mode = 2'b01;
    stretch("R9", 1'b1, 24);
    imb_mag = 4'd3; a_low = 1'b0;
    stretch("R9", 1'b0, 27);

    // R4 plain width, then a new edge cutting a running stretch
    do_reset();
    step(H); step(H); step(H); chk("R4", H, L);
    step(L); chk("R4", L, L);
    imb_mag = 4'd14; a_low = 1'b0;
    step(H); chk("R4", L, H);
    step(L); step(L); step(L); chk("R11", L, H);
    step(H); chk("R11", H, L);

    // tri hold-off boundary
    do_reset();
    step(H); chk("R5", H, L);
    for (int k = 1; k <= 12; k++) begin step(T); chk("R5", H, L); end
    step(H); chk("R5", H, L);
    for (int k = 1; k <= 13; k++) begin
      step(T);
      if (k < 13) chk("R5", H, L); else chk("R5", T, T);
    end
    step(L); chk("R5", L, L);
    step(H); chk("R5", L, H);

    // disable and re-arm
    do_reset();
    step(H); step(L); chk("R6", L, L);
    @(negedge clk); en = 1'b0; pin = H; @(posedge clk); #1; chk("R6", T, T);
    @(negedge clk); en = 1'b1; pin = L; @(posedge clk); #1; chk("R6", T, T);
    step(L); chk("R6", T, T);
    step(H); chk("R6", H, L);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule